// File: doc/BRIEF.md
# Configurable UART serial transmitter

This block is the transmit half of a classic asynchronous serial port. Software programs a line-format register that selects the character length, the parity scheme and the stop period, then writes characters one at a time into a single-entry holding register. The block moves each character into a shift register and sends it on one serial line: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and a high stop period. Bit timing comes from an external baud-tick pulse. Each bit lasts a fixed number of ticks, which is 16 by default.

Two status signals pace the writer. An active-low ready output goes low whenever the holding register can take another character, so the next character can be written while the current one is still on the line. An empty output is high only when there is nothing left to send at all. Besides odd and even parity, the block supports stick parity, where the parity bit is a constant, and a one-and-a-half-bit stop period for 5-bit characters.

Top module: `serial_tx`

## Requirements
- R1: Format bits [1:0] set the character length to 5, 6, 7 or 8 bits for codes 00, 01, 10 and 11. Data is sent least significant bit first. Written bits above the configured length are not sent and do not affect parity.
- R2: The line is 1 when idle. A frame opens with a 0 start bit. Start, data and parity bits each last 16 baud ticks.
- R3: Format bit 3 enables a parity bit after the data. When bit 3 is 0, the stop period follows the last data bit directly.
- R4: With parity enabled and bit 5 clear, format bit 4 = 1 gives even parity and bit 4 = 0 gives odd parity. Even parity means the data bits plus the parity bit hold an even number of ones.
- R5: With bits 3 and 5 set (stick parity), the parity bit is the inverse of bit 4: it is 0 when bit 4 is 1 and 1 when bit 4 is 0.
- R6: Format bit 2 = 0 gives a 16-tick stop period. Bit 2 = 1 gives 24 ticks for 5-bit characters and 32 ticks for longer ones.
- R7: The ready output (active low) is 1 from the cycle after a character write until the holding register is moved into the shifter. That move happens on the first baud tick on which the shifter is idle, or on the tick that ends the stop period. Consecutive frames therefore follow each other with no gap.
- R8: The empty output is 1 only when the holding register is empty and no frame is in progress.
- R9: A format write takes effect for the next character loaded. It does not change a frame already being sent.
- R10: After reset the line is 1, ready is 0 (active) and empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = holding register, 1 = line format register |
| wrData | input | 8 | Write data; format register uses bits [5:0] |
| baudTick | input | 1 | One-cycle baud tick pulse |
| txLine | output | 1 | Serial output line |
| holdReadyN | output | 1 | Low when the holding register can accept a character |
| txEmpty | output | 1 | High when the holding register and the shifter are both empty |

## Verification
The hardest case to reach from the ports is the hand-over at the end of a stop period: the next character has to be loaded on the very tick that ends the stop, with no extra idle time. Lengthening the stop period to 24 or 32 ticks makes this harder to observe. The bench reaches this case by writing a second character as soon as ready returns low, while the first frame is still on the line. It then measures the tick distance between the two start edges, which must equal the exact frame length for that format. A second difficult case is a format write landing in the middle of a frame. The bench makes this write after it has seen a start edge and checks that the frame still decodes with the old format.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Line format register, laid out so that a write of bits [5:0] casts directly.
  typedef struct packed {
    logic       parStick;  // bit 5
    logic       parEven;   // bit 4
    logic       parEn;     // bit 3
    logic       longStop;  // bit 2
    logic [1:0] lenSel;    // bits 1:0, length = 5 + lenSel
  } lineCfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic loadShift;   // move holding register into the shifter
    logic lineStart;   // drive start bit
    logic lineData;    // drive next data bit and shift
    logic lineParity;  // drive parity bit
    logic lineStop;    // drive stop level
  } txStrobe_t;

  localparam int MIN_LEN = 5;

endpackage

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int CNT_W         = $clog2(2 * TICKS_PER_BIT),
  parameter int IDX_W         = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobe_t         strobe,
  output logic              txLine,
  output logic              holdFull,
  output logic [IDX_W-1:0]  lastDataIdx,
  output logic              frameParEn,
  output logic [CNT_W-1:0]  stopLast
);

  localparam int HALF_BIT = TICKS_PER_BIT / 2;

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] lenMask;
  lineCfg_t          cfgReg;
  lineCfg_t          frameCfg;
  logic              parBit;
  logic              oddOnes;
  logic              newPar;

  // Mask of the bits that belong to the configured character length
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign lenMask[g] = (32'(g) < 32'(MIN_LEN) + 32'(cfgReg.lenSel));
  end

  assign oddOnes = ^(holdReg & lenMask);

  always_comb begin
    if (cfgReg.parStick)     newPar = ~cfgReg.parEven;
    else if (cfgReg.parEven) newPar = oddOnes;
    else                     newPar = ~oddOnes;
  end

  assign lastDataIdx = IDX_W'(MIN_LEN - 1) + IDX_W'(frameCfg.lenSel);
  assign frameParEn  = frameCfg.parEn;

  always_comb begin
    if (!frameCfg.longStop)          stopLast = CNT_W'(TICKS_PER_BIT - 1);
    else if (frameCfg.lenSel == 2'd0) stopLast = CNT_W'(TICKS_PER_BIT + HALF_BIT - 1);
    else                              stopLast = CNT_W'(2 * TICKS_PER_BIT - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      cfgReg   <= '0;
      frameCfg <= '0;
      shiftReg <= '0;
      parBit   <= 1'b0;
      txLine   <= 1'b1;
    end else begin
      if (wrEn && !wrSel) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end else if (strobe.loadShift) begin
        holdFull <= 1'b0;
      end

      if (wrEn && wrSel) cfgReg <= lineCfg_t'(wrData[5:0]);

      if (strobe.loadShift) begin
        shiftReg <= holdReg;
        frameCfg <= cfgReg;
        parBit   <= newPar;
      end

      if (strobe.lineStart) begin
        txLine <= 1'b0;
      end else if (strobe.lineData) begin
        txLine   <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end else if (strobe.lineParity) begin
        txLine <= parBit;
      end else if (strobe.lineStop) begin
        txLine <= 1'b1;
      end
    end
  end

  // R9: the frame format is only replaced by a load
  a_r9_frame_cfg_held: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadShift |=> $stable(frameCfg));

  // R2: a load opens the frame with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    strobe.loadShift |=> !txLine);

  // R7: a character write leaves the holding register occupied
  a_r7_full_after_write: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrSel) |=> holdFull);

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int CNT_W         = $clog2(2 * TICKS_PER_BIT),
  parameter int IDX_W         = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             baudTick,
  input  logic             holdFull,
  input  logic [IDX_W-1:0] lastDataIdx,
  input  logic             frameParEn,
  input  logic [CNT_W-1:0] stopLast,
  output txStrobe_t        strobe,
  output logic             busy
);

  txState_t         state, stateNext;
  logic [CNT_W-1:0] tickCnt, cntNext;
  logic [IDX_W-1:0] bitIdx, idxNext;
  logic [CNT_W-1:0] segLast;

  assign segLast = (state == ST_STOP) ? stopLast : CNT_W'(TICKS_PER_BIT - 1);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    cntNext   = tickCnt;
    idxNext   = bitIdx;
    if (baudTick) begin
      if (state == ST_IDLE) begin
        if (holdFull) begin
          stateNext        = ST_START;
          cntNext          = '0;
          strobe.loadShift = 1'b1;
          strobe.lineStart = 1'b1;
        end
      end else if (tickCnt == segLast) begin
        cntNext = '0;
        unique case (state)
          ST_START: begin
            stateNext       = ST_DATA;
            idxNext         = '0;
            strobe.lineData = 1'b1;
          end
          ST_DATA: begin
            if (bitIdx == lastDataIdx) begin
              if (frameParEn) begin
                stateNext         = ST_PARITY;
                strobe.lineParity = 1'b1;
              end else begin
                stateNext       = ST_STOP;
                strobe.lineStop = 1'b1;
              end
            end else begin
              idxNext         = bitIdx + 1'b1;
              strobe.lineData = 1'b1;
            end
          end
          ST_PARITY: begin
            stateNext       = ST_STOP;
            strobe.lineStop = 1'b1;
          end
          ST_STOP: begin
            if (holdFull) begin
              stateNext        = ST_START;
              strobe.loadShift = 1'b1;
              strobe.lineStart = 1'b1;
            end else begin
              stateNext = ST_IDLE;
            end
          end
          default: stateNext = ST_IDLE;
        endcase
      end else begin
        cntNext = tickCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNext;
      tickCnt <= cntNext;
      bitIdx  <= idxNext;
    end
  end

  // R3: the parity slot is only entered for frames that carry parity
  a_r3_parity_enabled: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PARITY) |-> frameParEn);

  // R6: the stop counter never runs past the selected stop length
  a_r6_stop_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP) |-> (tickCnt <= stopLast));

  // R7: a load only happens while a character is waiting
  a_r7_load_needs_data: assert property (@(posedge clk) disable iff (rst)
    strobe.loadShift |-> holdFull);

endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import sertx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  localparam int CNT_W        = $clog2(2 * TICKS_PER_BIT),
  localparam int IDX_W        = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              baudTick,
  output logic              txLine,
  output logic              holdReadyN,
  output logic              txEmpty
);

  txStrobe_t        strobe;
  logic             holdFull;
  logic             busy;
  logic [IDX_W-1:0] lastDataIdx;
  logic             frameParEn;
  logic [CNT_W-1:0] stopLast;

  sertx_ctrl #(
    .DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .baudTick(baudTick), .holdFull(holdFull),
    .lastDataIdx(lastDataIdx), .frameParEn(frameParEn), .stopLast(stopLast),
    .strobe(strobe), .busy(busy)
  );

  sertx_dp #(
    .DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strobe(strobe), .txLine(txLine), .holdFull(holdFull),
    .lastDataIdx(lastDataIdx), .frameParEn(frameParEn), .stopLast(stopLast)
  );

  assign holdReadyN = holdFull;
  assign txEmpty    = !holdFull && !busy;

  // R8: nothing pending means the line rests high
  a_r8_empty_line_high: assert property (@(posedge clk) disable iff (rst)
    txEmpty |-> txLine);

endmodule

// File: tb/sim_serial_tx.sv
`timescale 1ns/1ps
module sim_serial_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic       baudTick = 1'b0;
  logic       txLine, holdReadyN, txEmpty;

  serial_tx u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .baudTick(baudTick), .txLine(txLine), .holdReadyN(holdReadyN), .txEmpty(txEmpty)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Vectors: {format[5:0], first char, second char}
  // format: [5] stick, [4] even, [3] parity on, [2] long stop, [1:0] length
  localparam logic [21:0] VEC [0:14] = '{
    {6'b011000, 8'h55, 8'hAA},
    {6'b011100, 8'h5A, 8'hA5},
    {6'b001000, 8'h55, 8'h3F},
    {6'b001100, 8'hE5, 8'h05},
    {6'b111000, 8'h55, 8'hAA},
    {6'b101100, 8'h5A, 8'hA5},
    {6'b000000, 8'h55, 8'hAA},
    {6'b000100, 8'h1F, 8'hE0},
    {6'b011001, 8'h55, 8'hAA},
    {6'b001101, 8'h5A, 8'hA5},
    {6'b111101, 8'h3F, 8'hC0},
    {6'b011110, 8'h7F, 8'h80},
    {6'b101011, 8'hFF, 8'h00},
    {6'b001011, 8'hA5, 8'h5A},
    {6'b000111, 8'h01, 8'h80}
  };

  // Expected frame bits, index 0 = start bit
  function automatic logic [11:0] expFrame(input logic [5:0] cfg, input logic [7:0] d);
    logic [11:0] f;
    int n, ones;
    logic par;
    f = '0;
    n = 5 + int'(cfg[1:0]);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      f[1+i] = d[i];
      if (d[i]) ones++;
    end
    if (cfg[3]) begin
      if (cfg[5])      par = ~cfg[4];
      else if (cfg[4]) par = (ones % 2) == 1;
      else             par = (ones % 2) == 0;
      f[1+n] = par;
      f[2+n] = 1'b1;
    end else begin
      f[1+n] = 1'b1;
    end
    return f;
  endfunction

  function automatic int frameBits(input logic [5:0] cfg);
    return 2 + 5 + int'(cfg[1:0]) + int'(cfg[3]);  // includes one stop sample
  endfunction

  function automatic int frameTicks(input logic [5:0] cfg);
    int stopT;
    if (!cfg[2])              stopT = 16;
    else if (cfg[1:0] == 2'b0) stopT = 24;
    else                      stopT = 32;
    return 16 * (frameBits(cfg) - 1) + stopT;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Tick generator, tick counter, line monitor and watchdog
  int          ticks = 0;
  int          phase = 0;
  int          cycles = 0;
  logic        prevLine = 1'b1;
  logic        inFrame = 1'b0;
  int          startT = 0;
  int          idx = 0;
  int          lastSamp = -1;
  int          monTotal = 8;
  logic [11:0] curBits;
  logic [11:0] capBits [0:63];
  int          capStart [0:63];
  int          fc = 0;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst) begin
      baudTick = 1'b0;
    end else begin
      if (baudTick) ticks++;
      phase = (phase + 1) % 4;
      baudTick = (phase == 3);
      if (!inFrame && prevLine && !txLine) begin
        inFrame = 1'b1;
        startT = ticks;
        idx = 0;
        curBits = '0;
        if (fc < 64) capStart[fc] = ticks;
      end
      if (inFrame && ticks == startT + 8 + 16 * idx && ticks != lastSamp) begin
        lastSamp = ticks;
        curBits[idx] = txLine;
        idx++;
        if (idx == monTotal) begin
          inFrame = 1'b0;
          if (fc < 64) capBits[fc] = curBits;
          fc++;
        end
      end
    end
    prevLine = txLine;
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitEmpty();
    while (txEmpty !== 1'b1) @(negedge clk);
  endtask

  task automatic waitFrames(input int target);
    while (fc < target) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 line idle", 32'(txLine), 32'd1);
    chk("R10 ready", 32'(holdReadyN), 32'd0);
    chk("R10 empty", 32'(txEmpty), 32'd1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 line after release", 32'(txLine), 32'd1);

    // Vector walk: two back-to-back characters per format
    for (int v = 0; v < 15; v++) begin
      logic [5:0] cfg;
      logic [7:0] d1, d2;
      int base;
      {cfg, d1, d2} = VEC[v];
      waitEmpty();
      monTotal = frameBits(cfg);
      base = fc;
      wr(1'b1, {2'b00, cfg});
      wr(1'b0, d1);
      // R7/R8: the character now waits in the holding register
      chk("R7 ready high after write", 32'(holdReadyN), 32'd1);
      chk("R8 empty low while holding", 32'(txEmpty), 32'd0);
      while (holdReadyN !== 1'b0) @(negedge clk);
      wr(1'b0, d2);
      waitFrames(base + 2);
      // R1 R3 R4 R5: frame content
      chk("R1 R3 R4 R5 frame one", 32'(capBits[base]), 32'(expFrame(cfg, d1)));
      chk("R1 R3 R4 R5 frame two", 32'(capBits[base+1]), 32'(expFrame(cfg, d2)));
      // R2 R6 R7: start-to-start distance equals the full frame length
      chk("R6 R7 frame length", 32'(capStart[base+1] - capStart[base]), 32'(frameTicks(cfg)));
    end

    // R9: format written mid-frame must not disturb it
    begin
      int base;
      waitEmpty();
      chk("R2 idle high", 32'(txLine), 32'd1);
      monTotal = frameBits(6'b001011);
      base = fc;
      wr(1'b1, 8'b00001011);
      wr(1'b0, 8'hC3);
      while (!inFrame) @(negedge clk);
      repeat (40) @(negedge clk);
      chk("R8 empty low during frame", 32'(txEmpty), 32'd0);
      chk("R7 ready low during frame", 32'(holdReadyN), 32'd0);
      wr(1'b1, 8'b00111100);
      waitFrames(base + 1);
      chk("R9 frame kept old format", 32'(capBits[base]), 32'(expFrame(6'b001011, 8'hC3)));
      waitEmpty();
      monTotal = frameBits(6'b111100);
      base = fc;
      wr(1'b0, 8'h1B);
      waitFrames(base + 1);
      chk("R9 next frame uses new format", 32'(capBits[base]), 32'(expFrame(6'b111100, 8'h1B)));
      waitEmpty();
      chk("R8 empty after last frame", 32'(txEmpty), 32'd1);
      chk("R2 line high at end", 32'(txLine), 32'd1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule